// File: doc/BRIEF.md
# Configuration Image Header Ratio Selector

This block watches the 32-bit word stream that feeds a configuration port. It does not alter or forward the stream. After a start-of-image pulse it counts the accepted words from zero. It records whether the encryption field of one fixed header word is set, and whether the compression flag of a later fixed header word shows a compressed image. From these two facts and the selected port width it produces a 2-bit clock-to-data ratio code. The code is then held stable for the rest of the image.

A sequencer with four named states controls the block:

- `ST_IDLE`: the reset state. The block waits for a start pulse.
- `ST_COLLECT`: header words are being counted.
- `ST_DECIDED`: the ratio code is valid and frozen.
- `ST_FAULT`: the image ended before its header was complete.

The transitions are:

- A start pulse moves every state to `ST_COLLECT` and clears the outputs.
- In `ST_COLLECT`, acceptance of the compression word moves the block to `ST_DECIDED`.
- In `ST_COLLECT`, an end-of-image marker seen without that word moves the block to `ST_FAULT`.
- No other event changes the state.

Top module: `hdr_ratio_inspector`

## Requirements
- R1: After reset `ratio_vld_o` and `short_err_o` are 0, `ratio_o` is 0, and the block is in `ST_IDLE`, so words arriving before any start pulse have no effect.
- R2: Accepted words (`word_vld_i` high) are indexed from 0, starting with the first one after the cycle in which `sof_i` is high. A word presented in the same cycle as `sof_i` is not counted. The index stops at 229.
- R3: The image counts as encrypted when bits [3:2] of word index 69 are nonzero. No other word affects this.
- R4: The image counts as compressed when bit 1 of word index 229 is 0. No other word affects this.
- R5: Ratio codes are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. An image that is neither encrypted nor compressed gets code 0 at either width. `ratio_o` reads 0 whenever `ratio_vld_o` is low.
- R6: In every other case the base code is 2 if the image is compressed and 1 if it is not. The code is raised by one when `wide_i` is 1 (32-bit port), with `wide_i` sampled in the cycle that word 229 is accepted.
- R7: `ratio_vld_o` rises in the cycle after word 229 is accepted. It then stays high, with `ratio_o` unchanged, until the next `sof_i`. Later words, changes to `wide_i` and end markers are ignored during that time.
- R8: When `eoi_i` is high while collecting, and word 229 is not accepted in that same cycle, `short_err_o` rises in the next cycle. It holds until `sof_i`, and `ratio_vld_o` stays low. An end marker that arrives together with word 229 does not raise an error.
- R9: `sof_i` in any state clears `ratio_vld_o`, `short_err_o` and `ratio_o` in the next cycle and restarts the count.
- R10: Cycles with `word_vld_i` low do not advance the word index, so gaps in the stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-image pulse |
| word_vld_i | input | 1 | Qualifies `word_i` |
| word_i | input | 32 | Configuration data word |
| eoi_i | input | 1 | End-of-image marker |
| wide_i | input | 1 | Port width select: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_vld_o | output | 1 | Ratio code is valid |
| short_err_o | output | 1 | Image ended before the header was complete |

## Verification
The assertions assume that `sof_i` is a single-cycle pulse that comes before the words of its image. They also assume that `eoi_i` is raised at most once per image, and that the default parameters keep the encryption word ahead of the compression word. The stimulus drives every input at the falling edge and raises `sof_i` for exactly one cycle. It places word 229 last in each header, and sends extra words and end markers only after a decision or a fault has been reached. The filler words carry a set encryption field and a cleared compression bit, so a capture taken from the wrong index changes the result.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDED = 2'd2,
        ST_FAULT   = 2'd3
    } insp_state_e;

    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_code_e;

    typedef struct packed {
        logic encrypted;
        logic compressed;
    } hdr_flags_t;

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
    parameter int LIMIT = 229,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         at_limit
);

    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv && (cnt != LIM_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == LIM_V);

    // R2: index never runs past the last header word
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_V);

    // R10: idle cycles leave the index untouched
    p_cnt_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(cnt));

endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture
    import hdr_ratio_pkg::*;
#(
    parameter int ENC_IDX = 69,
    parameter int ENC_W   = 2,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [ENC_W-1:0] enc_field,
    input  logic             cmp_bit,
    output hdr_flags_t       flags_o
);

    localparam logic [IDX_W-1:0] ENC_IDX_V = IDX_W'(ENC_IDX);

    logic enc_hit;
    logic enc_q;
    logic at_enc;

    generate
        if (ENC_W == 1) begin : g_enc_single
            assign enc_hit = enc_field[0];
        end else begin : g_enc_multi
            assign enc_hit = |enc_field;
        end
    endgenerate

    assign at_enc = (idx == ENC_IDX_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= 1'b0;
        end else if (clr) begin
            enc_q <= 1'b0;
        end else if (take && at_enc) begin
            enc_q <= enc_hit;
        end
    end

    // compression flag is active-low in the header word, used in the cycle of capture
    always_comb begin
        flags_o.encrypted  = enc_q;
        flags_o.compressed = ~cmp_bit;
    end

    // R3: encryption flag changes only on the encryption word or a restart
    p_enc_only_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(take && at_enc)) |=> $stable(enc_q));

endmodule

// File: rtl/hdr_ratio_decide.sv
module hdr_ratio_decide
    import hdr_ratio_pkg::*;
(
    input  hdr_flags_t  flags,
    input  logic        wide,
    output ratio_code_e code
);

    logic [1:0] base;

    always_comb begin
        base = flags.compressed ? 2'(RATIO_X4) : 2'(RATIO_X2);
        if (!flags.encrypted && !flags.compressed) begin
            code = RATIO_X1;
        end else begin
            code = ratio_code_e'(base + {1'b0, wide});
        end
    end

endmodule

// File: rtl/hdr_seq_fsm.sv
module hdr_seq_fsm
    import hdr_ratio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic word_vld,
    input  logic last_word,
    input  logic eoi,
    output logic accept,
    output logic decide_now,
    output logic ratio_vld,
    output logic short_err
);

    insp_state_e state_q;
    insp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (sof) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: begin
                    if (word_vld && last_word) begin
                        state_d = ST_DECIDED;
                    end else if (eoi) begin
                        state_d = ST_FAULT;
                    end
                end
                ST_DECIDED: state_d = ST_DECIDED;
                ST_FAULT:   state_d = ST_FAULT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept     = (state_q == ST_COLLECT) && word_vld && !sof;
        decide_now = accept && last_word;
        ratio_vld  = (state_q == ST_DECIDED);
        short_err  = (state_q == ST_FAULT);
    end

    // R7: valid follows acceptance of the final header word
    p_decide_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        decide_now |=> ratio_vld);

    // R8: fault is sticky until restart
    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (short_err && !sof) |=> short_err);

    // R8: end marker without final word leads to fault
    p_eoi_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COLLECT) && !sof && eoi && !decide_now) |=> short_err);

endmodule

// File: rtl/hdr_ratio_inspector.sv
module hdr_ratio_inspector
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ENC_IDX = 69,
    parameter int ENC_LSB = 2,
    parameter int ENC_W   = 2,
    parameter int CMP_IDX = 229,
    parameter int CMP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              word_vld_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              eoi_i,
    input  logic              wide_i,
    output logic [1:0]        ratio_o,
    output logic              ratio_vld_o,
    output logic              short_err_o
);

    localparam int IDX_W = $clog2(CMP_IDX + 1);

    logic             accept;
    logic             decide_now;
    logic             last_word;
    logic [IDX_W-1:0] idx;
    hdr_flags_t       flags;
    ratio_code_e      code_d;
    logic [1:0]       ratio_q;

    hdr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof_i),
        .word_vld   (word_vld_i),
        .last_word  (last_word),
        .eoi        (eoi_i),
        .accept     (accept),
        .decide_now (decide_now),
        .ratio_vld  (ratio_vld_o),
        .short_err  (short_err_o)
    );

    hdr_word_counter #(
        .LIMIT (CMP_IDX)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sof_i),
        .adv      (accept),
        .cnt      (idx),
        .at_limit (last_word)
    );

    hdr_field_capture #(
        .ENC_IDX (ENC_IDX),
        .ENC_W   (ENC_W),
        .IDX_W   (IDX_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sof_i),
        .take      (accept),
        .idx       (idx),
        .enc_field (word_i[ENC_LSB +: ENC_W]),
        .cmp_bit   (word_i[CMP_BIT]),
        .flags_o   (flags)
    );

    hdr_ratio_decide u_dec (
        .flags (flags),
        .wide  (wide_i),
        .code  (code_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= 2'(RATIO_X1);
        end else if (sof_i) begin
            ratio_q <= 2'(RATIO_X1);
        end else if (decide_now) begin
            ratio_q <= 2'(code_d);
        end
    end

    assign ratio_o = ratio_q;

    // R7: decision frozen until restart
    p_ratio_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_vld_o && !sof_i) |=> (ratio_vld_o && $stable(ratio_o)));

    // R5: code reads x1 while not valid
    p_ratio_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_vld_o |-> (ratio_o == 2'(RATIO_X1)));

    // R8: error and valid never together
    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ratio_vld_o && short_err_o));

    // R9: restart clears all outputs
    p_sof_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (!ratio_vld_o && !short_err_o && (ratio_o == 2'(RATIO_X1))));

endmodule

// File: tb/hdr_ratio_inspector_test.sv
`timescale 1ns/1ps
module hdr_ratio_inspector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        word_vld_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        eoi_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [1:0]  ratio_o;
    logic        ratio_vld_o;
    logic        short_err_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    hdr_ratio_inspector uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .word_vld_i  (word_vld_i),
        .word_i      (word_i),
        .eoi_i       (eoi_i),
        .wide_i      (wide_i),
        .ratio_o     (ratio_o),
        .ratio_vld_o (ratio_vld_o),
        .short_err_o (short_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input bit e, input bit c, input bit w);
        if (!e && !c) return 0;
        return (c ? 2 : 1) + int'(w);
    endfunction

    // filler words look encrypted and compressed, so a wrong index shows up
    function automatic logic [31:0] mk(input int i, input logic [1:0] enc, input bit comp);
        logic [31:0] v;
        v = {16'(i), 16'hA5AC};
        if (i == 69)  v[3:2] = enc;
        if (i == 229) v[1] = ~comp;
        return v;
    endfunction

    task automatic pulse_sof();
        sof_i = 1'b1;
        @(negedge clk);
        sof_i = 1'b0;
    endtask

    task automatic send(input logic [31:0] w);
        word_vld_i = 1'b1;
        word_i = w;
        @(negedge clk);
        word_vld_i = 1'b0;
    endtask

    task automatic send_range(input int first, input int last,
                              input logic [1:0] enc, input bit comp, input bit gaps);
        for (int i = first; i <= last; i++) begin
            send(mk(i, enc, comp));
            if (gaps && (i % 7 == 3)) begin
                repeat (2) @(negedge clk);
            end
        end
    endtask

    task automatic run_image(input logic [1:0] enc, input bit comp, input bit w,
                             input bit gaps, input string req);
        pulse_sof();
        wide_i = w;
        send_range(0, 228, enc, comp, gaps);
        chk({req, " no early valid"}, int'(ratio_vld_o), 0);
        send(mk(229, enc, comp));
        chk({req, " valid"}, int'(ratio_vld_o), 1);
        chk({req, " ratio"}, int'(ratio_o), exp_ratio(enc != 2'b00, comp, w));
        chk({req, " no error"}, int'(short_err_o), 0);
    endtask

    task automatic t_reset();
        chk("R1 vld after reset", int'(ratio_vld_o), 0);
        chk("R1 err after reset", int'(short_err_o), 0);
        chk("R1 ratio after reset", int'(ratio_o), 0);
        for (int i = 0; i < 300; i++) send(32'h0);
        eoi_i = 1'b1; @(negedge clk); eoi_i = 1'b0;
        chk("R1 R2 words before start ignored vld", int'(ratio_vld_o), 0);
        chk("R1 words before start ignored err", int'(short_err_o), 0);
    endtask

    task automatic t_matrix();
        for (int w = 0; w < 2; w++)
            for (int e = 0; e < 4; e++)
                for (int c = 0; c < 2; c++)
                    run_image(2'(e), bit'(c), bit'(w), 1'b0, "R3 R4 R5 R6 matrix");
    endtask

    task automatic t_gaps();
        run_image(2'b10, 1'b1, 1'b1, 1'b1, "R10 gaps compressed wide");
        run_image(2'b00, 1'b0, 1'b0, 1'b1, "R10 gaps plain narrow");
    endtask

    task automatic t_hold();
        run_image(2'b01, 1'b0, 1'b0, 1'b0, "R7 setup");
        wide_i = 1'b1;
        for (int i = 0; i < 20; i++) send(32'h0000_0000);
        eoi_i = 1'b1; @(negedge clk); eoi_i = 1'b0;
        chk("R7 hold valid", int'(ratio_vld_o), 1);
        chk("R7 hold ratio", int'(ratio_o), 1);
        chk("R7 no error after late eoi", int'(short_err_o), 0);
    endtask

    task automatic t_short();
        pulse_sof();
        send_range(0, 99, 2'b11, 1'b1, 1'b0);
        eoi_i = 1'b1; @(negedge clk); eoi_i = 1'b0;
        chk("R8 early end err", int'(short_err_o), 1);
        chk("R8 early end vld", int'(ratio_vld_o), 0);
        send_range(100, 229, 2'b11, 1'b1, 1'b0);
        chk("R8 err holds", int'(short_err_o), 1);
        chk("R8 vld stays low", int'(ratio_vld_o), 0);
        pulse_sof();
        send_range(0, 228, 2'b11, 1'b1, 1'b0);
        eoi_i = 1'b1; @(negedge clk); eoi_i = 1'b0;
        chk("R8 end one word short err", int'(short_err_o), 1);
        pulse_sof();
        wide_i = 1'b0;
        send_range(0, 228, 2'b00, 1'b1, 1'b0);
        eoi_i = 1'b1;
        send(mk(229, 2'b00, 1'b1));
        eoi_i = 1'b0;
        chk("R8 end with final word no err", int'(short_err_o), 0);
        chk("R8 end with final word vld", int'(ratio_vld_o), 1);
        chk("R8 end with final word ratio", int'(ratio_o), 2);
    endtask

    task automatic t_sof();
        run_image(2'b11, 1'b1, 1'b1, 1'b0, "R9 setup");
        pulse_sof();
        chk("R9 sof clears vld", int'(ratio_vld_o), 0);
        chk("R9 sof clears ratio", int'(ratio_o), 0);
        chk("R9 sof clears err", int'(short_err_o), 0);
        // word in the start cycle must not be counted
        wide_i = 1'b0;
        sof_i = 1'b1; word_vld_i = 1'b1; word_i = 32'hFFFF_FFFF;
        @(negedge clk);
        sof_i = 1'b0; word_vld_i = 1'b0;
        send_range(0, 228, 2'b01, 1'b1, 1'b0);
        chk("R2 sof-cycle word not counted", int'(ratio_vld_o), 0);
        send(mk(229, 2'b01, 1'b1));
        chk("R2 decision at word 229", int'(ratio_vld_o), 1);
        chk("R2 ratio after restart", int'(ratio_o), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_matrix();
        t_gaps();
        t_hold();
        t_short();
        t_sof();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule